// File: doc/BRIEF.md
# Master Data Byte Buffer

This block is the small byte store that sits between a register-mapped host data port and a two-wire serial master engine. The host queues outgoing bytes by writing them one at a time to a single data address, and it drains incoming bytes by reading that same address. Each read returns the oldest byte and moves the rest toward the head. After a receive transfer, the engine can also deposit a whole group of bytes at once. The engine reads the stored bytes in parallel when it sends them.

The block tracks a signed fill index that is -1 when the store is empty and DEPTH-1 when it is full. It keeps two sticky status flags, one for "holds data" and one for "full". Events set and clear these flags; the flags are not decoded from the index. A flush strobe empties the store and zeroes its contents. Strobes that arrive in the same cycle are resolved by a fixed priority.

Top module: `mdb_buffer`

## Requirements
- R1: After synchronous reset the fill index is -1, both flags are low, and every stored byte is zero.
- R2: A host write while the index is below DEPTH-1 stores the byte at position index+1 and increments the index. A host write while the index equals DEPTH-1 changes nothing.
- R3: A host write that moves the index to 0 sets the has-data flag. A host write that moves it to DEPTH-1 sets the full flag.
- R4: While the index is -1, host_rdata is all ones (0xFF). A host read in that state changes no index, flag or byte.
- R5: While the index is 0 or more, host_rdata shows byte 0 in the same cycle as the read strobe. The read copies byte i+1 into byte i for every i below the index, leaves the bytes at and above the index unchanged, and decrements the index.
- R6: A host read taken while the index is DEPTH-1 clears the full flag. A host read taken while the index is 0 clears the has-data flag.
- R7: A flush sets the index to -1, zeroes every byte and clears both flags.
- R8: An engine load of N bytes copies eng_data bits [8i+7:8i] into byte i for each i below N and leaves the other bytes as they were. It sets the index to N-1. A count above DEPTH is treated as DEPTH. The load sets has-data when N is at least 1 and sets full when N equals DEPTH; otherwise it leaves both flags unchanged.
- R9: When strobes coincide, priority runs flush, then engine load, then host read, then host write. Only the winner takes effect.
- R10: tx_bytes bits [8i+7:8i] always carry stored byte i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe to the data address |
| host_rd | input | 1 | Host read strobe from the data address |
| host_wdata | input | DW | Byte written by the host |
| flush | input | 1 | Flush command |
| eng_load | input | 1 | Engine bulk-load strobe |
| eng_count | input | clog2(DEPTH+1) | Number of bytes in the engine load |
| eng_data | input | DEPTH*DW | Bytes from the engine, byte i at bits [8i+7:8i] |
| host_rdata | output | DW | Head byte, or all ones when empty |
| fill_idx | output | clog2(DEPTH)+1 | Signed fill index, -1 when empty |
| has_data | output | 1 | Sticky has-data flag |
| full | output | 1 | Sticky full flag |
| tx_bytes | output | DEPTH*DW | All stored bytes, for the engine to send |

## Verification
The bench pushes writes past capacity. A design that overwrote the last byte, or let the index wrap, would show a changed tx_bytes or an index of -1 after the fifth write. The bench also reads an empty store. A design that returned a stale byte instead of 0xFF, or decremented below -1, would be caught at once.

Loads with small counts are placed after a full store. They expose designs that derive the flags from the index instead of keeping them sticky, and designs that wipe the bytes above N. Reads are checked for shifting only the bytes below the index. A random phase then sends colliding strobes, to catch a wrong priority order where a dropped write or read alters the store.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

    typedef enum logic [2:0] {
        MDB_IDLE  = 3'd0,
        MDB_FLUSH = 3'd1,
        MDB_LOAD  = 3'd2,
        MDB_READ  = 3'd3,
        MDB_WRITE = 3'd4
    } mdb_op_e;

    // Winning operation and whether it actually alters state
    typedef struct packed {
        mdb_op_e op;
        logic    live;
    } mdb_cmd_t;

    // Fixed priority: flush, engine load, host read, host write
    function automatic mdb_op_e mdb_pick(input logic fl, input logic ld,
                                         input logic rd, input logic wr);
        if (fl)      return MDB_FLUSH;
        else if (ld) return MDB_LOAD;
        else if (rd) return MDB_READ;
        else if (wr) return MDB_WRITE;
        else         return MDB_IDLE;
    endfunction

endpackage

// File: rtl/mdb_arbiter.sv
module mdb_arbiter
    import mdb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         flush,
    input  logic                         eng_load,
    input  logic                         host_rd,
    input  logic                         host_wr,
    input  logic [$clog2(DEPTH+1)-1:0]   eng_count,
    input  logic                         is_empty,
    input  logic                         is_full,
    output mdb_cmd_t                     cmd,
    output logic [$clog2(DEPTH+1)-1:0]   load_n
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    always_comb begin
        cmd.op   = mdb_pick(flush, eng_load, host_rd, host_wr);
        load_n   = (eng_count > CAP) ? CAP : eng_count;
        unique case (cmd.op)
            MDB_READ:  cmd.live = !is_empty;
            MDB_WRITE: cmd.live = !is_full;
            MDB_IDLE:  cmd.live = 1'b0;
            default:   cmd.live = 1'b1;
        endcase
    end
endmodule

// File: rtl/mdb_track.sv
module mdb_track
    import mdb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  mdb_cmd_t                     cmd,
    input  logic [$clog2(DEPTH+1)-1:0]   load_n,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         is_empty,
    output logic                         is_full,
    output logic                         has_data,
    output logic                         full
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH-1);

    logic [CW-1:0] cnt_q;
    logic          has_q, full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            has_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (cmd.live) begin
            unique case (cmd.op)
                MDB_FLUSH: begin
                    cnt_q  <= '0;
                    has_q  <= 1'b0;
                    full_q <= 1'b0;
                end
                MDB_LOAD: begin
                    cnt_q <= load_n;
                    if (load_n != '0) has_q  <= 1'b1;
                    if (load_n == CAP) full_q <= 1'b1;
                end
                MDB_READ: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CAP)     full_q <= 1'b0;
                    if (cnt_q == CW'(1))  has_q  <= 1'b0;
                end
                MDB_WRITE: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == '0)   has_q  <= 1'b1;
                    if (cnt_q == LAST) full_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cnt      = cnt_q;
    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == CAP);
    assign has_data = has_q;
    assign full     = full_q;
endmodule

// File: rtl/mdb_store.sv
module mdb_store
    import mdb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  mdb_cmd_t                     cmd,
    input  logic [$clog2(DEPTH+1)-1:0]   cnt,
    input  logic [$clog2(DEPTH+1)-1:0]   load_n,
    input  logic [DW-1:0]                host_wdata,
    input  logic [DEPTH*DW-1:0]          eng_data,
    output logic [DEPTH*DW-1:0]          bytes_out
);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] upper;
        if (i < DEPTH-1) begin : g_mid
            assign upper = slot[i+1];
        end else begin : g_top
            assign upper = slot[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (cmd.live) begin
                unique case (cmd.op)
                    MDB_FLUSH: slot[i] <= '0;
                    MDB_LOAD:
                        if (CW'(i) < load_n) slot[i] <= eng_data[i*DW +: DW];
                    MDB_READ:
                        if (CW'(i+1) < cnt) slot[i] <= upper;
                    MDB_WRITE:
                        if (cnt == CW'(i)) slot[i] <= host_wdata;
                    default: ;
                endcase
            end
        end

        assign bytes_out[i*DW +: DW] = slot[i];
    end
endmodule

// File: rtl/mdb_buffer.sv
module mdb_buffer
    import mdb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               host_wr,
    input  logic                               host_rd,
    input  logic [DW-1:0]                      host_wdata,
    input  logic                               flush,
    input  logic                               eng_load,
    input  logic [$clog2(DEPTH+1)-1:0]         eng_count,
    input  logic [DEPTH*DW-1:0]                eng_data,
    output logic [DW-1:0]                      host_rdata,
    output logic signed [$clog2(DEPTH):0]      fill_idx,
    output logic                               has_data,
    output logic                               full,
    output logic [DEPTH*DW-1:0]                tx_bytes
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int IW = $clog2(DEPTH) + 1;

    mdb_cmd_t      cmd;
    logic [CW-1:0] load_n;
    logic [CW-1:0] cnt;
    logic          is_empty, is_full;

    mdb_arbiter #(.DEPTH(DEPTH)) u_arb (
        .flush     (flush),
        .eng_load  (eng_load),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .eng_count (eng_count),
        .is_empty  (is_empty),
        .is_full   (is_full),
        .cmd       (cmd),
        .load_n    (load_n)
    );

    mdb_track #(.DEPTH(DEPTH)) u_track (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_n   (load_n),
        .cnt      (cnt),
        .is_empty (is_empty),
        .is_full  (is_full),
        .has_data (has_data),
        .full     (full)
    );

    mdb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .cnt        (cnt),
        .load_n     (load_n),
        .host_wdata (host_wdata),
        .eng_data   (eng_data),
        .bytes_out  (tx_bytes)
    );

    assign fill_idx   = $signed(IW'(cnt) - IW'(1));
    assign host_rdata = is_empty ? {DW{1'b1}} : tx_bytes[DW-1:0];
endmodule

// File: rtl/mdb_buffer_chk.sv
module mdb_buffer_chk #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               host_wr,
    input logic                               host_rd,
    input logic                               flush,
    input logic                               eng_load,
    input logic [$clog2(DEPTH+1)-1:0]         eng_count,
    input logic [DW-1:0]                      host_rdata,
    input logic signed [$clog2(DEPTH):0]      fill_idx,
    input logic                               has_data,
    input logic                               full,
    input logic [DEPTH*DW-1:0]                tx_bytes
);
    localparam int IW = $clog2(DEPTH) + 1;
    localparam logic [IW-1:0] TOP  = IW'(DEPTH-1);
    localparam logic [IW-1:0] NONE = {IW{1'b1}};

    logic rd_only, wr_only;
    assign rd_only = host_rd && !flush && !eng_load;
    assign wr_only = host_wr && !host_rd && !flush && !eng_load;

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        (fill_idx == NONE) || (fill_idx >= 0 && fill_idx <= $signed(TOP)));

    assert_full_write_dropped_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_only && fill_idx == TOP) |=> (fill_idx == TOP) && $stable(tx_bytes));

    assert_write_sets_full_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_only && fill_idx == IW'(DEPTH-2)) |=> full);

    assert_empty_read_ff_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_only && fill_idx == NONE) |-> (host_rdata == {DW{1'b1}}));

    assert_empty_read_still_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_only && fill_idx == NONE) |=> (fill_idx == NONE) && $stable(tx_bytes));

    assert_read_decrements_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_only && fill_idx != NONE) |=> (fill_idx == $past(fill_idx) - IW'(1)));

    assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_only && fill_idx == TOP) |=> !full);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill_idx == NONE) && !has_data && !full && (tx_bytes == '0));

    assert_load_index_R8: assert property (@(posedge clk) disable iff (rst)
        (eng_load && !flush && eng_count <= DEPTH)
            |=> (fill_idx == $past(IW'(eng_count)) - IW'(1)));
endmodule

bind mdb_buffer mdb_buffer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .flush      (flush),
    .eng_load   (eng_load),
    .eng_count  (eng_count),
    .host_rdata (host_rdata),
    .fill_idx   (fill_idx),
    .has_data   (has_data),
    .full       (full),
    .tx_bytes   (tx_bytes)
);

// File: tb/mdb_buffer_bench.sv
module mdb_buffer_bench;
    localparam int DEPTH = 4;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH+1);
    localparam int IW    = $clog2(DEPTH) + 1;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   host_wr, host_rd, flush, eng_load;
    logic [DW-1:0]          host_wdata;
    logic [CW-1:0]          eng_count;
    logic [DEPTH*DW-1:0]    eng_data;
    logic [DW-1:0]          host_rdata;
    logic signed [IW-1:0]   fill_idx;
    logic                   has_data, full;
    logic [DEPTH*DW-1:0]    tx_bytes;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m [DEPTH];
    int idx;
    bit m_has, m_full;

    always #4 clk = ~clk;

    mdb_buffer #(.DEPTH(DEPTH), .DW(DW)) u_mdb_buffer (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .flush(flush), .eng_load(eng_load),
        .eng_count(eng_count), .eng_data(eng_data), .host_rdata(host_rdata),
        .fill_idx(fill_idx), .has_data(has_data), .full(full), .tx_bytes(tx_bytes)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "fill_idx", int'(fill_idx), idx);
        chk(req, "has_data", int'(has_data), int'(m_has));
        chk(req, "full", int'(full), int'(m_full));
        for (int i = 0; i < DEPTH; i++)
            chk({req, " R10"}, $sformatf("byte%0d", i), int'(tx_bytes[i*DW +: DW]), m[i]);
    endtask

    // apply one cycle of stimulus; called right after a falling edge
    task automatic step(input bit fl, input bit ld, input int n, input logic [DEPTH*DW-1:0] ed,
                        input bit rd, input bit wr, input int wd);
        string tag;
        int nn;
        flush = fl; eng_load = ld; eng_count = CW'(n); eng_data = ed;
        host_rd = rd; host_wr = wr; host_wdata = DW'(wd);
        #1;
        if (int'(fl) + int'(ld) + int'(rd) + int'(wr) > 1) tag = "R9";
        else tag = "";
        if (fl) begin
            idx = -1; m_has = 0; m_full = 0;
            for (int i = 0; i < DEPTH; i++) m[i] = 0;
            tag = {tag, " R7"};
        end else if (ld) begin
            nn = (n > DEPTH) ? DEPTH : n;
            for (int i = 0; i < nn; i++) m[i] = int'(ed[i*DW +: DW]);
            idx = nn - 1;
            if (nn > 0) m_has = 1;
            if (nn == DEPTH) m_full = 1;
            tag = {tag, " R8"};
        end else if (rd) begin
            if (idx < 0) begin
                chk("R4", "rdata empty", int'(host_rdata), 255);
                tag = {tag, " R4"};
            end else begin
                chk("R5", "rdata head", int'(host_rdata), m[0]);
                if (idx == DEPTH-1) m_full = 0;
                if (idx == 0) m_has = 0;
                for (int i = 0; i < idx; i++) m[i] = m[i+1];
                idx--;
                tag = {tag, " R5 R6"};
            end
        end else if (wr) begin
            if (idx < DEPTH-1) begin
                idx++;
                m[idx] = wd & 255;
                if (idx == 0) m_has = 1;
                if (idx == DEPTH-1) m_full = 1;
                tag = {tag, " R2 R3"};
            end else tag = {tag, " R2 full-drop"};
        end
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; host_wr = 0; host_rd = 0; flush = 0; eng_load = 0;
        host_wdata = '0; eng_count = '0; eng_data = '0;
        idx = -1; m_has = 0; m_full = 0;
        for (int i = 0; i < DEPTH; i++) m[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check_state("R1");
        chk("R1 R4", "rdata at reset", int'(host_rdata), 255);

        // R4: empty read
        step(0,0,0,'0, 1,0,0);
        // R2 R3: fill, then overflow write dropped
        step(0,0,0,'0, 0,1,8'h11);
        step(0,0,0,'0, 0,1,8'h22);
        step(0,0,0,'0, 0,1,8'h33);
        step(0,0,0,'0, 0,1,8'h44);
        step(0,0,0,'0, 0,1,8'h55);
        // R5 R6: drain with shift
        step(0,0,0,'0, 1,0,0);
        step(0,0,0,'0, 1,0,0);
        step(0,0,0,'0, 1,0,0);
        step(0,0,0,'0, 1,0,0);
        step(0,0,0,'0, 1,0,0);
        // R7: flush a partly filled store
        step(0,0,0,'0, 0,1,8'hA1);
        step(0,0,0,'0, 0,1,8'hA2);
        step(1,0,0,'0, 0,0,0);
        // R8: full load, then short load keeps full flag sticky
        step(0,1,4,32'hD4C3B2A1, 0,0,0);
        step(0,1,2,32'h00009988, 0,0,0);
        step(0,1,0,32'h0, 0,0,0);
        step(0,1,7,32'h77665544, 0,0,0);
        // R9: collisions
        step(0,1,1,32'h000000EE, 1,1,8'h12);
        step(1,1,3,32'h00ABCDEF, 1,1,8'h34);
        step(0,0,0,'0, 1,1,8'h56);
        step(0,0,0,'0, 1,1,8'h57);

        for (int k = 0; k < 3000; k++) begin
            int r;
            logic [DEPTH*DW-1:0] ed;
            r = int'($urandom_range(0, 99));
            ed = {$urandom, $urandom};
            step(r < 3, (r >= 3 && r < 11) || (r == 95), int'($urandom_range(0, 7)), ed,
                 (r >= 11 && r < 48) || r >= 95, r >= 48, int'($urandom_range(0, 255)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule